// File: doc/BRIEF.md
# Threshold-Gated Baseline Corrector

This block removes a slowly drifting baseline from a stream of 13-bit unsigned samples. It keeps a running baseline estimate, subtracts it from every valid sample, adds a signed digital offset and clamps the result to the 13-bit range. The corrected sample appears one clock after the input sample.

The estimate learns only from eligible samples. A sample is eligible when its amplitude lies inside a programmable window of absolute thresholds, counted in ADC counts from zero to full scale. In gated mode, a sample is also eligible only when it lies outside the acquisition window. This keeps pulses out of the estimate. In continuous mode, the acquisition-window flag has no effect on the estimate.

The estimate is an exponential moving average with a programmable shift factor. Its first value after reset is taken from the first eligible sample. The block is placed after sample capture and ahead of accumulation or storage.

Top module: `bc_baseline_corr`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `sample_o` is 0. For every cycle with `valid_i` high, `valid_o` is high exactly one clock later.
- R2: A valid sample is eligible for the estimate only if `thr_lo_i <= sample_i <= thr_hi_i`, with both bounds inclusive. An out-of-range sample leaves the estimate unchanged.
- R3: `mode_i` = 0 selects continuous mode, in which `in_window_i` is ignored. `mode_i` = 1 selects gated mode, in which a sample with `in_window_i` = 1 leaves the estimate unchanged.
- R4: After reset, the estimate is not yet seeded and the baseline used for correction is 0. The first eligible sample loads the fixed-point estimate E with `sample_i * 2^6`.
- R5: Each later eligible sample x updates the estimate as `E <= E + floor((x*2^6 - E) / 2^shift_i)`. With `shift_i` = 0, E becomes x*2^6.
- R6: For each valid sample x, the output is `x - floor(E/2^6) + offset_i`. E is the estimate held before this sample updates it, and `offset_i` is a 13-bit two's-complement number.
- R7: The result of R6 is saturated. A negative value gives 0, and a value above 8191 gives 8191.
- R8: In a cycle with `valid_i` low, `valid_o` goes low one clock later and `sample_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is valid |
| sample_i | input | 13 | Input sample, unsigned ADC counts |
| in_window_i | input | 1 | Sample lies inside the acquisition window |
| mode_i | input | 1 | 0: continuous estimate, 1: estimate only outside the acquisition window |
| thr_lo_i | input | 13 | Lower amplitude bound for eligibility, inclusive |
| thr_hi_i | input | 13 | Upper amplitude bound for eligibility, inclusive |
| shift_i | input | 4 | Averaging shift factor k |
| offset_i | input | 13 | Signed digital offset added after subtraction |
| valid_o | output | 1 | Corrected sample is valid |
| sample_o | output | 13 | Corrected, saturated sample |

## Verification
Each corrected sample is due one clock after its input. The estimate update from the same sample becomes visible only in the output of the next sample, which arrives one clock later again. The bench drives inputs on the falling edge and compares the outputs on the following falling edge. Expected values come from an arithmetic model of E, so a missed or wrongly applied update shows up in the next compared output. Ignored samples are each followed by a probe sample, and that probe's output exposes whether the baseline moved.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef enum logic {
    EST_CONT  = 1'b0,
    EST_GATED = 1'b1
  } est_mode_e;
endpackage

// File: rtl/bc_gate.sv
module bc_gate #(
  parameter int DATA_W = 13
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              in_window_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  output logic              elig_o
);
  import bc_pkg::*;

  logic in_range;
  logic win_ok;

  assign in_range = (sample_i >= thr_lo_i) && (sample_i <= thr_hi_i);
  assign win_ok   = (est_mode_e'(mode_i) == EST_CONT) || !in_window_i;
  assign elig_o   = valid_i && in_range && win_ok;
endmodule

// File: rtl/bc_ema.sv
module bc_ema #(
  parameter int DATA_W  = 13,
  parameter int FRAC_W  = 6,
  parameter int SHIFT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [DATA_W-1:0]  base_o,
  output logic               seeded_o
);
  localparam int ACC_W = DATA_W + FRAC_W;

  logic [ACC_W-1:0]      est_q, est_d;
  logic                  seeded_q;
  logic [ACC_W-1:0]      smp_fx;
  logic signed [ACC_W:0] diff, step, sum;

  assign smp_fx = {sample_i, {FRAC_W{1'b0}}};
  assign diff   = $signed({1'b0, smp_fx}) - $signed({1'b0, est_q});
  assign step   = diff >>> shift_i;
  assign sum    = $signed({1'b0, est_q}) + step;

  // convex step: sum stays within [0, 2^ACC_W)
  always_comb begin
    est_d = est_q;
    if (upd_i) est_d = seeded_q ? sum[ACC_W-1:0] : smp_fx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_q    <= '0;
      seeded_q <= 1'b0;
    end else begin
      est_q <= est_d;
      if (upd_i) seeded_q <= 1'b1;
    end
  end

  assign base_o   = est_q[ACC_W-1:FRAC_W];
  assign seeded_o = seeded_q;
endmodule

// File: rtl/bc_out.sv
module bc_out #(
  parameter int DATA_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] sample_o
);
  localparam int RES_W = DATA_W + 2;
  localparam logic signed [RES_W-1:0] MAX_V = RES_W'((1 << DATA_W) - 1);

  logic signed [RES_W-1:0] res;
  logic [DATA_W-1:0]       sat;

  assign res = $signed({2'b00, sample_i}) - $signed({2'b00, base_i})
             + $signed({{2{offset_i[DATA_W-1]}}, offset_i});

  always_comb begin
    if (res < 0)          sat = '0;
    else if (res > MAX_V) sat = '1;
    else                  sat = res[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= sat;
    end
  end
endmodule

// File: rtl/bc_baseline_corr.sv
module bc_baseline_corr #(
  parameter int DATA_W  = 13,
  parameter int FRAC_W  = 6,
  parameter int SHIFT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic               in_window_i,
  input  logic               mode_i,
  input  logic [DATA_W-1:0]  thr_lo_i,
  input  logic [DATA_W-1:0]  thr_hi_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [DATA_W-1:0]  offset_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  sample_o
);
  logic              elig;
  logic              seeded;
  logic [DATA_W-1:0] base;

  bc_gate #(.DATA_W(DATA_W)) u_gate (
    .valid_i    (valid_i),
    .sample_i   (sample_i),
    .in_window_i(in_window_i),
    .mode_i     (mode_i),
    .thr_lo_i   (thr_lo_i),
    .thr_hi_i   (thr_hi_i),
    .elig_o     (elig)
  );

  bc_ema #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)) u_ema (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (elig),
    .sample_i(sample_i),
    .shift_i (shift_i),
    .base_o  (base),
    .seeded_o(seeded)
  );

  bc_out #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sample_i(sample_i),
    .base_i  (base),
    .offset_i(offset_i),
    .valid_o (valid_o),
    .sample_o(sample_o)
  );
endmodule

// File: rtl/bc_baseline_corr_chk.sv
module bc_baseline_corr_chk #(
  parameter int DATA_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] sample_i,
  input logic              in_window_i,
  input logic              mode_i,
  input logic [DATA_W-1:0] thr_hi_i,
  input logic [DATA_W-1:0] thr_lo_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] sample_o,
  input logic [DATA_W-1:0] base,
  input logic              seeded
);
  // R1
  out_follows_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(sample_o)));

  // R2
  above_range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sample_i > thr_hi_i) |=> $stable(base));

  // R2
  below_range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sample_i < thr_lo_i) |=> $stable(base));

  // R3
  gated_window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i && in_window_i) |=> $stable(base));

  // R4
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seeded) |-> (base == $past(sample_i)));

  // R4
  unseeded_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seeded |-> (base == '0));
endmodule

bind bc_baseline_corr bc_baseline_corr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .sample_i   (sample_i),
  .in_window_i(in_window_i),
  .mode_i     (mode_i),
  .thr_hi_i   (thr_hi_i),
  .thr_lo_i   (thr_lo_i),
  .valid_o    (valid_o),
  .sample_o   (sample_o),
  .base       (base),
  .seeded     (seeded)
);

// File: tb/bc_baseline_corr_tb_top.sv
module bc_baseline_corr_tb_top;
  localparam int DW = 13;
  localparam int FW = 6;
  localparam int SW = 4;
  localparam int MAXV = (1 << DW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          in_window_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [DW-1:0] thr_lo_i = '0;
  logic [DW-1:0] thr_hi_i = '0;
  logic [SW-1:0] shift_i = '0;
  logic [DW-1:0] offset_i = '0;
  logic          valid_o;
  logic [DW-1:0] sample_o;

  int     errs = 0;
  int     chks = 0;
  bit     done = 0;
  longint m_est = 0;
  bit     m_seed = 0;
  int     lo_v, hi_v, off_v, sh_v, md_v;

  always #4 clk_i = ~clk_i;

  bc_baseline_corr dut_i (.*);

  task automatic chk(string tag, longint got, longint exp);
    chks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic cfg(int lo, int hi, int off, int sh, int md);
    lo_v = lo; hi_v = hi; off_v = off; sh_v = sh; md_v = md;
    thr_lo_i = DW'(lo); thr_hi_i = DW'(hi); offset_i = DW'(off);
    shift_i = SW'(sh); mode_i = md[0];
  endtask

  // drives at a falling edge, compares on the next one
  task automatic send(string tag, int x, bit w);
    longint b, y, fx;
    bit el;
    b = m_seed ? (m_est >>> FW) : 0;
    y = x - b + off_v;
    if (y < 0) y = 0;
    if (y > MAXV) y = MAXV;
    el = (x >= lo_v) && (x <= hi_v) && (md_v == 0 || !w);
    if (el) begin
      fx = longint'(x) <<< FW;
      if (!m_seed) m_est = fx;
      else m_est = m_est + ((fx - m_est) >>> sh_v);
      m_seed = 1;
    end
    valid_i = 1'b1; sample_i = DW'(x); in_window_i = w;
    @(negedge clk_i);
    chk({tag, " valid"}, valid_o, 1);
    chk({tag, " data"}, sample_o, y);
  endtask

  task automatic idle(string tag);
    longint prev;
    prev = sample_o;
    valid_i = 1'b0; sample_i = DW'(1234);
    @(negedge clk_i);
    chk({tag, " valid low"}, valid_o, 0);
    chk({tag, " data held"}, sample_o, prev);
  endtask

  task automatic do_reset(string tag);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    m_est = 0; m_seed = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk({tag, " rst valid"}, valid_o, 0);
    chk({tag, " rst data"}, sample_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    int seed;
    cfg(100, 4000, 0, 2, 0);
    @(negedge clk_i);
    do_reset("R1");

    send("R4 unseeded out of range", 5000, 0);
    send("R4 seed sample", 1000, 0);
    send("R6 seeded baseline", 1000, 0);
    send("R3 mode0 window ignored", 2000, 1);
    send("R5 ema step", 1250, 0);
    idle("R8 idle");
    send("R1 after idle", 1300, 0);

    // R2 boundaries, each followed by a probe
    send("R2 below lo", 99, 0);    send("R2 probe", 1500, 0);
    send("R2 at lo", 100, 0);      send("R2 probe", 1500, 0);
    send("R2 at hi", 4000, 0);     send("R2 probe", 1500, 0);
    send("R2 above hi", 4001, 0);  send("R2 probe", 1500, 0);

    // R3 gated mode
    cfg(100, 4000, 0, 1, 1);
    send("R3 gated in window", 3500, 1);
    send("R3 probe", 1500, 0);
    send("R3 gated outside window", 3500, 0);
    send("R3 probe", 1500, 0);

    // R7 saturation both ways
    cfg(100, 4000, -4096, 3, 0);
    send("R7 clamp low", 200, 0);
    cfg(100, 8191, 4095, 3, 0);
    send("R7 clamp high", 8191, 0);
    cfg(0, 8191, 2000, 0, 0);
    send("R5 shift zero", 300, 0);
    send("R6 offset positive", 300, 0);

    // sweep shift, mode, offset over a noisy baseline with pulses
    seed = 7;
    for (int sh = 0; sh < 8; sh++) begin
      for (int md = 0; md < 2; md++) begin
        cfg(800, 2600, (sh * 701) % 3000 - 1500, sh, md);
        for (int i = 0; i < 48; i++) begin
          int x;
          bit w;
          seed = seed * 1103515245 + 12345;
          w = (i % 6) >= 4;
          x = 1500 + ((seed >>> 8) & 255) - 128;
          if (w) x = x + 3000 + ((seed >>> 4) & 1023);
          if (i % 11 == 0) x = (seed >>> 3) & MAXV;
          send("R5 R6 sweep", x, w);
          if (i % 13 == 0) idle("R8 sweep idle");
        end
      end
    end

    // R4 reseed after a second reset
    do_reset("R1 second");
    cfg(100, 4000, 50, 4, 1);
    send("R4 unseeded window", 2000, 1);
    send("R4 reseed", 600, 0);
    send("R4 after reseed", 700, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule